// File: doc/BRIEF.md
# Tagged Stream FIFO Link

This block is a one-way channel that carries 32-bit words from a producer (typically a processor) to a consumer (typically a hardware accelerator), or in the opposite direction. Next to each data word the writer supplies a one-bit tag that marks the word as either a control word or a plain data word. Tag and data travel together through a first-in first-out store whose depth is a parameter.

The reader asks for either a data word or a control word. Each read is blocking or nonblocking, and each write is blocking or nonblocking. When the tag of the word at the head does not match the kind of read, the word is still delivered, and a sticky error flag is set. The flag stays set until the reader requests a clear. A separate availability bit records, for the most recent read, whether a word was actually delivered. A nonblocking read of an empty store sets this bit to 0 and returns zero.

The asynchronous active-low reset is released synchronously inside the block. All read results and flags are registered. Write and read acknowledges are combinational from the request and the registered full and empty flags.

Top module: `tagfifo_link`

## Requirements
- R1: After reset, fifo_empty is 1, fifo_full is 0, err_flag is 0, rd_avail is 0, rd_data is 0 and rd_tag is 0.
- R2: Words are returned in the order they were written, and each word is returned with the tag it was written with on rd_tag (1 = control word, 0 = data word).
- R3: A blocking write (wr_nb = 0) is not acknowledged while fifo_full is 1. It is acknowledged and stored in the first cycle in which fifo_full is 0.
- R4: A nonblocking write (wr_nb = 1) is always acknowledged in the cycle it is requested. wr_fail is 1 only when fifo_full is 1, and in that case the word is discarded. With fifo_full at 0, wr_fail is 0 and the word is stored.
- R5: A blocking read (rd_nb = 0) is not acknowledged while fifo_empty is 1. It completes in the first cycle in which a word is present.
- R6: A nonblocking read (rd_nb = 1) on an empty store is acknowledged at once. After the clock edge, rd_data is 0, rd_tag is 0 and rd_avail is 0, and nothing is removed from the store.
- R7: A read whose kind (rd_ctl: 1 = expects control, 0 = expects data) differs from the head word's tag still removes the word and returns it, and it sets err_flag at that clock edge.
- R8: err_flag is sticky. Later reads with a matching kind leave it at 1.
- R9: err_flag returns to 0 at the edge after err_clr is held high in a cycle with no mismatched read. If a mismatched read occurs in the same cycle as err_clr, err_flag is 1 after the edge.
- R10: rd_avail is rewritten at every acknowledged read: 1 when a word was delivered, 0 otherwise. rd_avail, rd_data and rd_tag do not change in cycles without an acknowledged read.
- R11: fifo_full and fifo_empty are registered and follow the occupancy after each edge. fifo_full becomes 1 once DEPTH words are held, and fifo_empty becomes 1 once the last word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, held until wr_ack |
| wr_nb | input | 1 | 1 = nonblocking write |
| wr_ctl | input | 1 | Tag of the word written (1 = control) |
| wr_data | input | DATA_W | Word written |
| wr_ack | output | 1 | Write acknowledged this cycle |
| wr_fail | output | 1 | Nonblocking write found the store full |
| rd_req | input | 1 | Read request, held until rd_ack |
| rd_nb | input | 1 | 1 = nonblocking read |
| rd_ctl | input | 1 | Kind of read (1 = expects control word) |
| err_clr | input | 1 | Clears the sticky mismatch flag |
| rd_ack | output | 1 | Read acknowledged this cycle |
| rd_data | output | DATA_W | Word from the last acknowledged read |
| rd_tag | output | 1 | Tag of the word from the last acknowledged read |
| rd_avail | output | 1 | Last acknowledged read delivered a word |
| err_flag | output | 1 | Sticky tag-mismatch flag |
| fifo_full | output | 1 | Store holds DEPTH words |
| fifo_empty | output | 1 | Store holds no word |

## Verification
On every cycle, the assertions check the following:
- the flags against an occupancy count kept in the checker;
- that blocking reads are held off on an empty store;
- that write failure happens only on a full store;
- that the error flag holds and clears as specified;
- that read results stay unchanged between acknowledged reads.

Only the bench's scenarios can show that words come back in order with their tags, that a mismatched word is still delivered, that a failed nonblocking write really discards its word, and that a blocked writer or reader resumes at the right moment.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;

  // Kind of word, used both as the stored tag and as the kind of read
  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_CTRL = 1'b1
  } word_kind_e;

  // A read of one kind that meets a word of the other kind
  function automatic logic kind_mismatch(input logic head_tag, input logic rd_kind);
    return head_tag != rd_kind;
  endfunction

endpackage

// File: rtl/tagfifo_rst_sync.sv
module tagfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end

endmodule

// File: rtl/tagfifo_store.sv
module tagfifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ENT_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] wentry,
  output logic [ENT_W-1:0] head,
  output logic             full,
  output logic             empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d;
  logic          empty_q, empty_d;

  // next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + AW'(1);
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + AW'(1);
    cnt_d   = cnt_q + CW'(push) - CW'(pop);
    full_d  = (cnt_d == CNT_MAX);
    empty_d = (cnt_d == '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      full_q   <= full_d;
      empty_q  <= empty_d;
    end
  end

  // storage, written under its own enable
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wentry;
  end

  assign head  = mem[rd_ptr_q];
  assign full  = full_q;
  assign empty = empty_q;

endmodule

// File: rtl/tagfifo_rd_port.sv
module tagfifo_rd_port
  import tagfifo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              rd_nb,
  input  logic              rd_ctl,
  input  logic              err_clr,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_tag,
  output logic              rd_ack,
  output logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              rd_avail,
  output logic              err_flag
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              tag_q, tag_d;
  logic              avail_q, avail_d;
  logic              err_q, err_d;
  logic              bad_kind;

  assign pop      = rd_req && !empty;
  assign rd_ack   = rd_req && (rd_nb || !empty);
  assign bad_kind = pop && kind_mismatch(head_tag, rd_ctl);

  // next state
  always_comb begin
    data_d  = data_q;
    tag_d   = tag_q;
    avail_d = avail_q;
    if (rd_ack) begin
      data_d  = pop ? head_data : '0;
      tag_d   = pop ? head_tag  : 1'b0;
      avail_d = pop;
    end
    if (bad_kind)     err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      tag_q   <= 1'b0;
      avail_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      data_q  <= data_d;
      tag_q   <= tag_d;
      avail_q <= avail_d;
      err_q   <= err_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_tag   = tag_q;
  assign rd_avail = avail_q;
  assign err_flag = err_q;

endmodule

// File: rtl/tagfifo_link.sv
module tagfifo_link #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_nb,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  output logic              wr_fail,
  input  logic              rd_req,
  input  logic              rd_nb,
  input  logic              rd_ctl,
  input  logic              err_clr,
  output logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              rd_avail,
  output logic              err_flag,
  output logic              fifo_full,
  output logic              fifo_empty
);

  localparam int unsigned ENT_W = DATA_W + 1;

  logic             srst_n;
  logic             push;
  logic             pop;
  logic [ENT_W-1:0] head;

  tagfifo_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // write handshake
  assign push    = wr_req && !fifo_full;
  assign wr_ack  = wr_req && (wr_nb || !fifo_full);
  assign wr_fail = wr_req && wr_nb && fifo_full;

  tagfifo_store #(
    .DEPTH (DEPTH),
    .ENT_W (ENT_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (srst_n),
    .push   (push),
    .pop    (pop),
    .wentry ({wr_ctl, wr_data}),
    .head   (head),
    .full   (fifo_full),
    .empty  (fifo_empty)
  );

  tagfifo_rd_port #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_req    (rd_req),
    .rd_nb     (rd_nb),
    .rd_ctl    (rd_ctl),
    .err_clr   (err_clr),
    .empty     (fifo_empty),
    .head_data (head[DATA_W-1:0]),
    .head_tag  (head[DATA_W]),
    .rd_ack    (rd_ack),
    .pop       (pop),
    .rd_data   (rd_data),
    .rd_tag    (rd_tag),
    .rd_avail  (rd_avail),
    .err_flag  (err_flag)
  );

endmodule

// File: rtl/tagfifo_link_chk.sv
module tagfifo_link_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic              push,
  input logic              pop,
  input logic              wr_req,
  input logic              wr_nb,
  input logic              wr_ack,
  input logic              wr_fail,
  input logic              rd_req,
  input logic              rd_nb,
  input logic              rd_ack,
  input logic              err_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_tag,
  input logic              rd_avail,
  input logic              err_flag,
  input logic              fifo_full,
  input logic              fifo_empty
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) occ_q <= '0;
    else         occ_q <= occ_q + CW'(push) - CW'(pop);
  end

  // R11
  flags_track_occ_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fifo_full == (occ_q == CW'(DEPTH))) && (fifo_empty == (occ_q == '0)));

  // R3
  wr_block_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_req && !wr_nb && fifo_full |-> !wr_ack);

  // R4
  wr_fail_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_fail |-> wr_nb && fifo_full && wr_ack);

  // R5
  rd_block_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_req && !rd_nb && fifo_empty |-> !rd_ack);

  // R6
  nb_empty_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_req && rd_nb && fifo_empty |=> !rd_avail && (rd_data == '0) && !rd_tag);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    err_flag && !err_clr |=> err_flag);

  // R9
  err_clr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    err_clr && !(rd_req && !fifo_empty) |=> !err_flag);

  // R10
  avail_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_ack |=> $stable(rd_avail) && $stable(rd_data) && $stable(rd_tag));

endmodule

bind tagfifo_link tagfifo_link_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .srst_n     (srst_n),
  .push       (push),
  .pop        (pop),
  .wr_req     (wr_req),
  .wr_nb      (wr_nb),
  .wr_ack     (wr_ack),
  .wr_fail    (wr_fail),
  .rd_req     (rd_req),
  .rd_nb      (rd_nb),
  .rd_ack     (rd_ack),
  .err_clr    (err_clr),
  .rd_data    (rd_data),
  .rd_tag     (rd_tag),
  .rd_avail   (rd_avail),
  .err_flag   (err_flag),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty)
);

// File: tb/tagfifo_link_tb_top.sv
`timescale 1ns/1ps
module tagfifo_link_tb_top;

  localparam int unsigned DEPTH  = 16;
  localparam int unsigned DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              wr_req, wr_nb, wr_ctl;
  logic [DATA_W-1:0] wr_data;
  logic              wr_ack, wr_fail;
  logic              rd_req, rd_nb, rd_ctl, err_clr;
  logic              rd_ack;
  logic [DATA_W-1:0] rd_data;
  logic              rd_tag, rd_avail, err_flag, fifo_full, fifo_empty;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DATA_W:0] exp_q[$];

  tagfifo_link #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_nb(wr_nb), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_fail(wr_fail),
    .rd_req(rd_req), .rd_nb(rd_nb), .rd_ctl(rd_ctl), .err_clr(err_clr),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_tag(rd_tag), .rd_avail(rd_avail),
    .err_flag(err_flag), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // driver: one write, pushes the expected item when the word is stored
  task automatic do_write(input logic ctl, input logic [DATA_W-1:0] d, input logic nb,
                          output logic failed);
    @(negedge clk);
    wr_req = 1'b1; wr_nb = nb; wr_ctl = ctl; wr_data = d;
    #1;
    while (!wr_ack) begin @(negedge clk); #1; end
    failed = wr_fail;
    @(posedge clk); #1;
    wr_req = 1'b0;
    if (!failed) exp_q.push_back({ctl, d});
  endtask

  // monitor side: one read, compares the delivered word with the scoreboard
  task automatic do_read(input string req, input logic kind, input logic nb,
                         output logic avail);
    logic [DATA_W:0] exp;
    @(negedge clk);
    rd_req = 1'b1; rd_nb = nb; rd_ctl = kind;
    #1;
    while (!rd_ack) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rd_req = 1'b0;
    avail = rd_avail;
    if (rd_avail) begin
      if (exp_q.size() == 0) check({req, " unexpected word"}, 64'(rd_avail), 64'd0);
      else begin
        exp = exp_q.pop_front();
        check({req, " data"}, 64'(rd_data), 64'(exp[DATA_W-1:0]));
        check({req, " tag"},  64'(rd_tag),  64'(exp[DATA_W]));
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic f, av;
    rst_n = 1'b0;
    wr_req = 0; wr_nb = 0; wr_ctl = 0; wr_data = '0;
    rd_req = 0; rd_nb = 0; rd_ctl = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 empty", 64'(fifo_empty), 64'd1);
    check("R1 full",  64'(fifo_full),  64'd0);
    check("R1 err",   64'(err_flag),   64'd0);
    check("R1 avail", 64'(rd_avail),   64'd0);
    check("R1 data",  64'(rd_data),    64'd0);
    check("R1 tag",   64'(rd_tag),     64'd0);

    // R2 order and tags, R10 avail set on delivery
    do_write(1'b0, 32'h1111_2222, 1'b0, f);
    do_write(1'b1, 32'hA5A5_0001, 1'b0, f);
    do_write(1'b0, 32'h0000_1234, 1'b1, f);
    check("R4 nb write with space", 64'(f), 64'd0);
    do_read("R2 w0", 1'b0, 1'b0, av);
    check("R10 avail after read", 64'(av), 64'd1);
    do_read("R2 w1", 1'b1, 1'b0, av);
    do_read("R2 w2", 1'b0, 1'b1, av);
    check("R2 no error on matched reads", 64'(err_flag), 64'd0);

    // R6 nonblocking read on empty, R10 avail rewritten to 0
    do_read("R6", 1'b0, 1'b1, av);
    check("R6 avail", 64'(av), 64'd0);
    check("R6 data zero", 64'(rd_data), 64'd0);
    check("R6 still empty", 64'(fifo_empty), 64'd1);
    check("R10 avail cleared", 64'(rd_avail), 64'd0);

    // R5 blocking read waits for a word
    fork
      do_read("R5", 1'b1, 1'b0, av);
      begin
        repeat (3) begin @(negedge clk); #2; check("R5 held off", 64'(rd_ack), 64'd0); end
        do_write(1'b1, 32'hBEEF_0005, 1'b0, f);
      end
    join
    check("R5 completed", 64'(av), 64'd1);

    // R7 mismatch still delivers and sets error
    do_write(1'b0, 32'hDEAD_0007, 1'b0, f);
    do_read("R7", 1'b1, 1'b0, av);
    check("R7 delivered", 64'(av), 64'd1);
    check("R7 err set", 64'(err_flag), 64'd1);
    check("R7 popped", 64'(fifo_empty), 64'd1);

    // R8 sticky across a matched read
    do_write(1'b1, 32'h0000_0008, 1'b0, f);
    do_read("R8", 1'b1, 1'b0, av);
    check("R8 err still set", 64'(err_flag), 64'd1);

    // R9 explicit clear
    @(negedge clk); err_clr = 1'b1;
    @(posedge clk); #1; err_clr = 1'b0;
    check("R9 cleared", 64'(err_flag), 64'd0);
    // R9 clear and mismatch in the same cycle
    do_write(1'b1, 32'h0000_0009, 1'b0, f);
    err_clr = 1'b1;
    do_read("R9 both", 1'b0, 1'b0, av);
    err_clr = 1'b0;
    check("R9 set wins", 64'(err_flag), 64'd1);
    @(negedge clk); err_clr = 1'b1;
    @(posedge clk); #1; err_clr = 1'b0;

    // R11 fill to full
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) check("R11 not full early", 64'(fifo_full), 64'd0);
      do_write(1'(i % 3 == 0), 32'hC000_0000 + 32'(i), 1'b0, f);
    end
    check("R11 full", 64'(fifo_full), 64'd1);

    // R4 nonblocking write on full is dropped
    do_write(1'b0, 32'hFFFF_FFFF, 1'b1, f);
    check("R4 wr_fail", 64'(f), 64'd1);

    // R3 blocking write waits for space
    @(negedge clk);
    wr_req = 1'b1; wr_nb = 1'b0; wr_ctl = 1'b1; wr_data = 32'h3333_0003;
    repeat (3) begin @(negedge clk); #1; check("R3 held off", 64'(wr_ack), 64'd0); end
    do_read("R3 make room", 1'b1, 1'b0, av);
    @(negedge clk); #1;
    check("R3 ack after room", 64'(wr_ack), 64'd1);
    @(posedge clk); #1;
    wr_req = 1'b0;
    exp_q.push_back({1'b1, 32'h3333_0003});

    // drain, all with reads of the kind matching the stored tag
    while (exp_q.size() > 0) begin
      do_read("R2 drain", exp_q[0][DATA_W], 1'b0, av);
    end
    check("R11 empty after drain", 64'(fifo_empty), 64'd1);
    check("R8 err clean after drain", 64'(err_flag), 64'd0);
    do_read("R4 dropped word absent", 1'b0, 1'b1, av);
    check("R4 dropped word absent", 64'(av), 64'd0);

    summary();
    $finish;
  end

endmodule